// File: doc/BRIEF.md
# Dual-Lane Fixed-Point Coefficient Multiply-Accumulator

This block multiplies pairs of 16-bit samples by four programmable 16-bit coefficients and keeps two independent 32-bit running sums. The two sums form a high lane and a low lane, and they leave the block together as one 64-bit word. The samples come from two 32-bit input words, A and B, and each word holds two 16-bit halves. On every accepted word, each lane forms two products, rescales them, adds them together, and then either accumulates that sum or starts a new sum with it.

An operation mode chooses which half-word meets which coefficient, so the same four multipliers can serve several jobs:
- a cross-mix of A and B,
- a merge that gives each word its own lane,
- a two-tap FIR over a stream of half-words,
- a 2x2 matrix transform of the halves of A.

The data and the coefficients can each be taken as signed or unsigned. The product's binary point can be moved to one of three positions, with rounding. Each lane's accumulator is limited to a programmable window, and a sticky flag records any clamping.

Configuration goes through a small write port. The sample stream is qualified by a valid strobe. Results appear one clock edge after the word is accepted.

Top module: `duallane_mac`

## Requirements
- R1: After reset the following hold:
  - `outData` = 0, `outValid` = 0 and `satFlag` = 0.
  - All four coefficients are 0 and the convolution history sample is 0.
  - Every lane window is the full signed 32-bit range.
- R2: A write with `cfgWe`=1 loads `cfgData` into the register chosen by `cfgAddr`:
  - addresses 0, 1, 2 and 3 load coefficients k00, k01, k10 and k11 from `cfgData[15:0]`;
  - addresses 4 and 5 load the low lane minimum and maximum;
  - addresses 6 and 7 load the high lane minimum and maximum.
  The new value applies to words accepted in later cycles. A configuration write on its own changes no output.
- R3: `opMode`=0 (cross-mix): high lane term = k10·B[31:16] + k11·A[31:16]; low lane term = k00·B[15:0] + k01·A[15:0].
- R4: `opMode`=1 (merge): high lane term = k10·A[31:16] + k11·A[15:0]; low lane term = k00·B[31:16] + k01·B[15:0].
- R5: `opMode`=2 (two-tap FIR). Word A gives two samples, A[15:0] first and then A[31:16].
  - Low lane term = k00·A[15:0] + k01·H, where H is A[31:16] from the previous word accepted in this mode (0 after reset).
  - High lane term = k10·A[31:16] + k11·A[15:0].
  - H is updated only by words accepted in this mode.
- R6: `opMode`=3 (transform): both lanes take the halves of A. High lane term = k10·A[31:16] + k11·A[15:0]; low lane term = k00·A[31:16] + k01·A[15:0].
- R7: When `dataSigned`=1, every sample half is read as two's complement; otherwise it is unsigned. `coefSigned` does the same for the coefficients.
- R8: `bpSel` sets the shift applied to each product before the two are added: 0 shifts by 0 bits, 1 by 15 bits, and 2 or 3 by 30 bits. A shift by s>0 adds 2^(s-1) and then shifts arithmetically right (round half up).
- R9: For an accepted word, `accClr`=1 makes the lane result equal to the new term. `accClr`=0 adds the new term to the lane's previous result.
- R10: Each lane's result is limited to its window [min, max], compared as signed values. The lower limit is tested first. Any limiting in lane i sets `satFlag[i]`, which stays set until reset.
- R11: `outValid` is 1 exactly one cycle after a cycle with `inValid`=1. `outData`={high lane, low lane} and `satFlag` change only at the edge that accepts a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select |
| cfgData | input | 32 | Configuration write data |
| inValid | input | 1 | Accept the sample words this cycle |
| opMode | input | 2 | Operand routing: 0 mix, 1 merge, 2 FIR, 3 transform |
| accClr | input | 1 | Start a new sum instead of accumulating |
| dataSigned | input | 1 | Sample halves are two's complement |
| coefSigned | input | 1 | Coefficients are two's complement |
| bpSel | input | 2 | Product binary-point position |
| wordA | input | 32 | Operand word A |
| wordB | input | 32 | Operand word B |
| outValid | output | 1 | A new result is on outData |
| outData | output | 64 | {high lane, low lane} results |
| satFlag | output | 2 | Sticky per-lane clamp flags |

## Verification
The assertions assume that reset is held low through the first clock edge. They also assume that the control inputs carry defined values whenever reset is released. They make no assumption about the window registers. They only tie result and flag changes to accepted words, and they require the flags to stay set once set.

The stimulus sweeps every mode, every signedness pair and all three binary points. It uses operands at the extremes of 16-bit range, so that the full-range window does clamp at times. Configuration writes are never issued in the same cycle as an accepted word, so no result depends on write-versus-use ordering.

// File: rtl/duallane_mac_pkg.sv
package duallane_mac_pkg;

  typedef enum logic [1:0] {
    MODE_MIX   = 2'd0,
    MODE_MERGE = 2'd1,
    MODE_CONV  = 2'd2,
    MODE_XFORM = 2'd3
  } macMode_t;

  // Where a multiplier input half-word is taken from
  typedef enum logic [2:0] {
    SRC_A_LO = 3'd0,
    SRC_A_HI = 3'd1,
    SRC_B_LO = 3'd2,
    SRC_B_HI = 3'd3,
    SRC_TAP  = 3'd4
  } srcSel_t;

  localparam int NUM_COEF  = 4;
  localparam int NUM_BOUND = 4;

  // Strobes from control to datapath. src[lane][term]
  typedef struct packed {
    logic [NUM_COEF-1:0]  coefLoad;
    logic [NUM_BOUND-1:0] boundLoad;
    logic                 step;
    logic                 clear;
    logic                 tapShift;
    srcSel_t [1:0][1:0]   src;
  } ctrlStrobe_t;

endpackage

// File: rtl/duallane_mac_ctrl.sv
module duallane_mac_ctrl
  import duallane_mac_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              inValid,
  input  logic [1:0]        opMode,
  input  logic              accClr,
  output ctrlStrobe_t       strobe,
  output logic              outValid
);

  macMode_t mode;
  assign mode = macMode_t'(opMode);

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_COEF; i++) begin
      strobe.coefLoad[i] = cfgWe && (cfgAddr == ADDR_W'(i));
    end
    for (int i = 0; i < NUM_BOUND; i++) begin
      strobe.boundLoad[i] = cfgWe && (cfgAddr == ADDR_W'(NUM_COEF + i));
    end
    strobe.step     = inValid;
    strobe.clear    = accClr;
    strobe.tapShift = inValid && (mode == MODE_CONV);
    unique case (mode)
      MODE_MIX: begin
        strobe.src[0][0] = SRC_B_LO;
        strobe.src[0][1] = SRC_A_LO;
        strobe.src[1][0] = SRC_B_HI;
        strobe.src[1][1] = SRC_A_HI;
      end
      MODE_MERGE: begin
        strobe.src[0][0] = SRC_B_HI;
        strobe.src[0][1] = SRC_B_LO;
        strobe.src[1][0] = SRC_A_HI;
        strobe.src[1][1] = SRC_A_LO;
      end
      MODE_CONV: begin
        strobe.src[0][0] = SRC_A_LO;
        strobe.src[0][1] = SRC_TAP;
        strobe.src[1][0] = SRC_A_HI;
        strobe.src[1][1] = SRC_A_LO;
      end
      default: begin
        strobe.src[0][0] = SRC_A_HI;
        strobe.src[0][1] = SRC_A_LO;
        strobe.src[1][0] = SRC_A_HI;
        strobe.src[1][1] = SRC_A_LO;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/duallane_mac_lane.sv
module duallane_mac_lane #(
  parameter int HALF_W = 16,
  parameter int COEF_W = 16,
  parameter int LANE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  input  logic              clear,
  input  logic [HALF_W-1:0] x0,
  input  logic [HALF_W-1:0] x1,
  input  logic [COEF_W-1:0] c0,
  input  logic [COEF_W-1:0] c1,
  input  logic              dataSigned,
  input  logic              coefSigned,
  input  logic [1:0]        bpSel,
  input  logic [LANE_W-1:0] boundMin,
  input  logic [LANE_W-1:0] boundMax,
  output logic [LANE_W-1:0] acc,
  output logic              sat
);

  localparam int EXT_W     = ((HALF_W > COEF_W) ? HALF_W : COEF_W) + 1;
  localparam int PROD_W    = 2 * EXT_W;
  localparam int SUM_W     = PROD_W + 1;
  localparam int ACC_W     = ((SUM_W > LANE_W) ? SUM_W : LANE_W) + 2;
  localparam int SHIFT_MID = HALF_W - 1;
  localparam int SHIFT_TOP = 2 * (HALF_W - 1);
  localparam logic signed [PROD_W-1:0] RND_MID = PROD_W'(1) <<< (SHIFT_MID - 1);
  localparam logic signed [PROD_W-1:0] RND_TOP = PROD_W'(1) <<< (SHIFT_TOP - 1);

  function automatic logic signed [PROD_W-1:0] scaledProduct(
    input logic [HALF_W-1:0] x,
    input logic [COEF_W-1:0] c,
    input logic              ds,
    input logic              cs,
    input logic [1:0]        bp
  );
    logic signed [EXT_W-1:0]  xe;
    logic signed [EXT_W-1:0]  ce;
    logic signed [PROD_W-1:0] xw;
    logic signed [PROD_W-1:0] cw;
    logic signed [PROD_W-1:0] p;
    xe = EXT_W'($signed({ds & x[HALF_W-1], x}));
    ce = EXT_W'($signed({cs & c[COEF_W-1], c}));
    xw = PROD_W'(xe);
    cw = PROD_W'(ce);
    p  = xw * cw;
    case (bp)
      2'd0:    scaledProduct = p;
      2'd1:    scaledProduct = (p + RND_MID) >>> SHIFT_MID;
      default: scaledProduct = (p + RND_TOP) >>> SHIFT_TOP;
    endcase
  endfunction

  logic signed [PROD_W-1:0] prod0;
  logic signed [PROD_W-1:0] prod1;
  logic signed [SUM_W-1:0]  term;
  logic signed [ACC_W-1:0]  prevAcc;
  logic signed [ACC_W-1:0]  nextAcc;
  logic signed [ACC_W-1:0]  limLo;
  logic signed [ACC_W-1:0]  limHi;
  logic signed [ACC_W-1:0]  limited;
  logic                     hitLimit;
  logic [LANE_W-1:0]        accQ;
  logic                     satQ;

  always_comb begin
    prod0   = scaledProduct(x0, c0, dataSigned, coefSigned, bpSel);
    prod1   = scaledProduct(x1, c1, dataSigned, coefSigned, bpSel);
    term    = SUM_W'(prod0) + SUM_W'(prod1);
    prevAcc = ACC_W'($signed(accQ));
    nextAcc = clear ? ACC_W'(term) : (prevAcc + ACC_W'(term));
    limLo   = ACC_W'($signed(boundMin));
    limHi   = ACC_W'($signed(boundMax));
    if (nextAcc < limLo) begin
      limited  = limLo;
      hitLimit = 1'b1;
    end else if (nextAcc > limHi) begin
      limited  = limHi;
      hitLimit = 1'b1;
    end else begin
      limited  = nextAcc;
      hitLimit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      satQ <= 1'b0;
    end else if (step) begin
      accQ <= LANE_W'(limited);
      if (hitLimit) satQ <= 1'b1;
    end
  end

  assign acc = accQ;
  assign sat = satQ;

endmodule

// File: rtl/duallane_mac_datapath.sv
module duallane_mac_datapath
  import duallane_mac_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int COEF_W = 16,
  parameter int LANE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [LANE_W-1:0]   cfgData,
  input  logic [2*HALF_W-1:0] wordA,
  input  logic [2*HALF_W-1:0] wordB,
  input  logic                dataSigned,
  input  logic                coefSigned,
  input  logic [1:0]          bpSel,
  output logic [2*LANE_W-1:0] outData,
  output logic [1:0]          satFlag
);

  localparam int NUM_LANES = 2;
  localparam logic [LANE_W-1:0] FULL_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] FULL_MAX = {1'b0, {(LANE_W-1){1'b1}}};

  logic [COEF_W-1:0] coefQ  [NUM_COEF];
  logic [LANE_W-1:0] boundQ [NUM_BOUND];
  logic [HALF_W-1:0] tapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_COEF; i++) coefQ[i] <= '0;
      for (int i = 0; i < NUM_BOUND; i++) boundQ[i] <= i[0] ? FULL_MAX : FULL_MIN;
      tapQ <= '0;
    end else begin
      for (int i = 0; i < NUM_COEF; i++)
        if (strobe.coefLoad[i]) coefQ[i] <= cfgData[COEF_W-1:0];
      for (int i = 0; i < NUM_BOUND; i++)
        if (strobe.boundLoad[i]) boundQ[i] <= cfgData;
      if (strobe.tapShift) tapQ <= wordA[2*HALF_W-1:HALF_W];
    end
  end

  function automatic logic [HALF_W-1:0] pickHalf(
    input srcSel_t           s,
    input logic [2*HALF_W-1:0] a,
    input logic [2*HALF_W-1:0] b,
    input logic [HALF_W-1:0] t
  );
    case (s)
      SRC_A_LO: pickHalf = a[HALF_W-1:0];
      SRC_A_HI: pickHalf = a[2*HALF_W-1:HALF_W];
      SRC_B_LO: pickHalf = b[HALF_W-1:0];
      SRC_B_HI: pickHalf = b[2*HALF_W-1:HALF_W];
      default:  pickHalf = t;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [HALF_W-1:0] x0;
    logic [HALF_W-1:0] x1;
    logic [LANE_W-1:0] laneAcc;
    logic              laneSat;

    assign x0 = pickHalf(strobe.src[g][0], wordA, wordB, tapQ);
    assign x1 = pickHalf(strobe.src[g][1], wordA, wordB, tapQ);

    duallane_mac_lane #(
      .HALF_W(HALF_W),
      .COEF_W(COEF_W),
      .LANE_W(LANE_W)
    ) uLane (
      .clk       (clk),
      .rstN      (rstN),
      .step      (strobe.step),
      .clear     (strobe.clear),
      .x0        (x0),
      .x1        (x1),
      .c0        (coefQ[2*g]),
      .c1        (coefQ[2*g+1]),
      .dataSigned(dataSigned),
      .coefSigned(coefSigned),
      .bpSel     (bpSel),
      .boundMin  (boundQ[2*g]),
      .boundMax  (boundQ[2*g+1]),
      .acc       (laneAcc),
      .sat       (laneSat)
    );

    assign outData[g*LANE_W +: LANE_W] = laneAcc;
    assign satFlag[g] = laneSat;
  end

endmodule

// File: rtl/duallane_mac.sv
module duallane_mac
  import duallane_mac_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int COEF_W = 16,
  parameter int LANE_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [LANE_W-1:0]   cfgData,
  input  logic                inValid,
  input  logic [1:0]          opMode,
  input  logic                accClr,
  input  logic                dataSigned,
  input  logic                coefSigned,
  input  logic [1:0]          bpSel,
  input  logic [2*HALF_W-1:0] wordA,
  input  logic [2*HALF_W-1:0] wordB,
  output logic                outValid,
  output logic [2*LANE_W-1:0] outData,
  output logic [1:0]          satFlag
);

  ctrlStrobe_t strobe;

  duallane_mac_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .inValid (inValid),
    .opMode  (opMode),
    .accClr  (accClr),
    .strobe  (strobe),
    .outValid(outValid)
  );

  duallane_mac_datapath #(
    .HALF_W(HALF_W),
    .COEF_W(COEF_W),
    .LANE_W(LANE_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgData   (cfgData),
    .wordA     (wordA),
    .wordB     (wordB),
    .dataSigned(dataSigned),
    .coefSigned(coefSigned),
    .bpSel     (bpSel),
    .outData   (outData),
    .satFlag   (satFlag)
  );

endmodule

// File: rtl/duallane_mac_chk.sv
module duallane_mac_chk #(
  parameter int LANE_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                outValid,
  input logic [2*LANE_W-1:0] outData,
  input logic [1:0]          satFlag
);

  // R11: a result follows every accepted word
  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R11: no result without an accepted word
  p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R11: results hold while idle (covers config-only cycles of R2)
  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outData) && $stable(satFlag)));

  // R10: clamp flags are sticky
  p_sat_sticky_lo_r10: assert property (@(posedge clk) disable iff (!rstN)
    satFlag[0] |=> satFlag[0]);

  p_sat_sticky_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    satFlag[1] |=> satFlag[1]);

endmodule

bind duallane_mac duallane_mac_chk #(.LANE_W(LANE_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outData (outData),
  .satFlag (satFlag)
);

// File: tb/sim_duallane_mac.sv
module sim_duallane_mac;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic [1:0]  opMode = '0;
  logic        accClr = 1'b0;
  logic        dataSigned = 1'b0;
  logic        coefSigned = 1'b0;
  logic [1:0]  bpSel = '0;
  logic [31:0] wordA = '0;
  logic [31:0] wordB = '0;
  logic        outValid;
  logic [63:0] outData;
  logic [1:0]  satFlag;

  int testsRun = 0;
  int testsFailed = 0;

  // reference state
  logic [15:0] coefM [4];
  longint      bMin [2];
  longint      bMax [2];
  longint      accM [2];
  logic [1:0]  satM;
  logic [15:0] tapM;

  always #10 clk = ~clk;

  duallane_mac u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .opMode(opMode), .accClr(accClr), .dataSigned(dataSigned),
    .coefSigned(coefSigned), .bpSel(bpSel), .wordA(wordA), .wordB(wordB),
    .outValid(outValid), .outData(outData), .satFlag(satFlag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint ext16(input logic [15:0] v, input bit sgn);
    return sgn ? longint'($signed(v)) : longint'(v);
  endfunction

  // R7, R8: product in the chosen signedness, rescaled with round half up
  function automatic longint prodM(input logic [15:0] c, input logic [15:0] x,
                                   input bit cs, input bit ds, input int bp);
    longint p;
    int s;
    p = ext16(c, cs) * ext16(x, ds);
    s = (bp == 0) ? 0 : ((bp == 1) ? 15 : 30);
    if (s > 0) p = (p + (64'sd1 <<< (s - 1))) >>> s;
    return p;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) coefM[i] = '0;
    for (int i = 0; i < 2; i++) begin
      bMin[i] = -64'sd2147483648;
      bMax[i] = 64'sd2147483647;
      accM[i] = 0;
    end
    satM = '0;
    tapM = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic cfgWrite(input logic [2:0] addr, input logic [31:0] data);
    cfgWe = 1'b1; cfgAddr = addr; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
    if (addr < 4) coefM[addr] = data[15:0];
    else if (addr[0] == 1'b0) bMin[addr[1]] = longint'($signed(data));
    else bMax[addr[1]] = longint'($signed(data));
  endtask

  task automatic doStep(input string tag, input logic [1:0] m, input logic clr,
                        input bit ds, input bit cs, input int bp,
                        input logic [31:0] a, input logic [31:0] b);
    logic [15:0] xs [2][2];
    longint      term;
    longint      nv;
    inValid = 1'b1; opMode = m; accClr = clr; dataSigned = ds; coefSigned = cs;
    bpSel = 2'(bp); wordA = a; wordB = b;
    @(negedge clk);
    inValid = 1'b0;
    case (m)
      2'd0: begin xs[0][0] = b[15:0];  xs[0][1] = a[15:0]; xs[1][0] = b[31:16]; xs[1][1] = a[31:16]; end // R3
      2'd1: begin xs[0][0] = b[31:16]; xs[0][1] = b[15:0]; xs[1][0] = a[31:16]; xs[1][1] = a[15:0];  end // R4
      2'd2: begin xs[0][0] = a[15:0];  xs[0][1] = tapM;    xs[1][0] = a[31:16]; xs[1][1] = a[15:0];  end // R5
      default: begin xs[0][0] = a[31:16]; xs[0][1] = a[15:0]; xs[1][0] = a[31:16]; xs[1][1] = a[15:0]; end // R6
    endcase
    for (int l = 0; l < 2; l++) begin
      term = prodM(coefM[2*l], xs[l][0], cs, ds, bp) + prodM(coefM[2*l+1], xs[l][1], cs, ds, bp);
      nv = clr ? term : accM[l] + term;                 // R9
      if (nv < bMin[l]) begin nv = bMin[l]; satM[l] = 1'b1; end       // R10
      else if (nv > bMax[l]) begin nv = bMax[l]; satM[l] = 1'b1; end
      accM[l] = nv;
    end
    if (m == 2'd2) tapM = a[31:16];
    check(tag, outData, {accM[1][31:0], accM[0][31:0]});
    check({tag, " R10 flags"}, {62'd0, satFlag}, {62'd0, satM});
    check("R11 valid", {63'd0, outValid}, 64'd1);
  endtask

  function automatic logic [31:0] patA(input int k);
    case (k)
      0: return 32'h7FFF_8000;
      1: return 32'hFFFF_0001;
      2: return 32'h1234_ABCD;
      default: return 32'h8000_8000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    string tags [4];
    logic [63:0] held;
    tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";

    @(negedge clk);
    doReset();
    // R1: reset state
    check("R1 data", outData, 64'd0);
    check("R1 valid", {63'd0, outValid}, 64'd0);
    check("R1 flags", {62'd0, satFlag}, 64'd0);
    // R1: coefficients are zero after reset
    doStep("R1 zero coef", 2'd0, 1'b1, 1'b0, 1'b0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R2: loading coefficients changes later results, not the output itself
    held = outData;
    cfgWrite(3'd0, 32'h0000_0003);
    cfgWrite(3'd1, 32'h0000_FFFE);
    cfgWrite(3'd2, 32'h0000_7FFF);
    cfgWrite(3'd3, 32'h0000_8000);
    check("R2 cfg no output effect", outData, held);
    check("R11 idle valid", {63'd0, outValid}, 64'd0);
    doStep("R2 R3 coef effect", 2'd0, 1'b1, 1'b1, 1'b1, 0, 32'h0002_0005, 32'h0001_0007);

    // Sweep: every mode, R7 signedness pair, R8 binary point, four patterns.
    for (int m = 0; m < 4; m++)
      for (int sg = 0; sg < 4; sg++)
        for (int bp = 0; bp < 3; bp++)
          for (int k = 0; k < 4; k++)
            doStep(tags[m], 2'(m), (k == 0), sg[0], sg[1], bp, patA(k), patA(3 - k));

    // R5: history is untouched by words in other modes
    doStep("R5 prime", 2'd2, 1'b1, 1'b1, 1'b1, 0, 32'h0040_0011, 32'h0);
    doStep("R5 other mode", 2'd3, 1'b1, 1'b1, 1'b1, 0, 32'h7777_1111, 32'h0);
    doStep("R5 history", 2'd2, 1'b1, 1'b1, 1'b1, 0, 32'h0001_0002, 32'h0);

    // R8: rounding boundaries
    doReset();
    cfgWrite(3'd0, 32'h0000_0001);
    cfgWrite(3'd2, 32'h0000_0001);
    doStep("R8 half up", 2'd3, 1'b1, 1'b1, 1'b1, 1, 32'h4000_4000, 32'h0);
    doStep("R8 below half", 2'd3, 1'b1, 1'b1, 1'b1, 1, 32'h3FFF_3FFF, 32'h0);
    doStep("R8 neg half", 2'd3, 1'b1, 1'b1, 1'b1, 1, 32'hC000_C000, 32'h0);
    doStep("R8 bpSel 3", 2'd3, 1'b1, 1'b0, 1'b0, 3, 32'hFFFF_FFFF, 32'h0);

    // R9: accumulate then restart
    doStep("R9 clear", 2'd1, 1'b1, 1'b1, 1'b1, 0, 32'h0010_0020, 32'h0030_0040);
    doStep("R9 add", 2'd1, 1'b0, 1'b1, 1'b1, 0, 32'h0010_0020, 32'h0030_0040);
    doStep("R9 add neg", 2'd1, 1'b0, 1'b1, 1'b1, 0, 32'hFF00_0020, 32'hFFF0_0040);
    doStep("R9 restart", 2'd1, 1'b1, 1'b1, 1'b1, 0, 32'h0001_0001, 32'h0002_0002);

    // R10: narrow window on the low lane only
    doReset();
    cfgWrite(3'd0, 32'h0000_0001);
    cfgWrite(3'd2, 32'h0000_0001);
    cfgWrite(3'd4, 32'hFFFF_FF9C);
    cfgWrite(3'd5, 32'h0000_0064);
    doStep("R10 upper", 2'd0, 1'b1, 1'b1, 1'b1, 0, 32'h0, 32'h0001_00C8);
    doStep("R10 sticky", 2'd0, 1'b0, 1'b1, 1'b1, 0, 32'h0, 32'h0001_FFFF);
    doStep("R10 lower", 2'd0, 1'b1, 1'b1, 1'b1, 0, 32'h0, 32'h0001_FF00);

    // R11: idle cycle keeps data and drops valid
    held = outData;
    @(negedge clk);
    check("R11 hold data", outData, held);
    check("R11 hold valid", {63'd0, outValid}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule